// File: doc/BRIEF.md
# TF32 Tile Matrix Multiply-Accumulate Engine

This block holds three small tiles of single-precision values (two sources and one destination) in internal register arrays. On a start pulse it computes, for every active destination row, the sum of products of the source tiles and then adds the old destination value. Before each multiply, both source operands are cut down to TF32 precision: a signaling NaN is first made quiet, and then the thirteen least significant mantissa bits are cleared. One fp32 multiplier and one fp32 adder are shared by every step of the loop nest, so each run takes one cycle per product plus a few cycles per row.

The tiles are loaded and read back one 32-bit element at a time through a single host port. The port selects a tile, a row and a column. The shape of a run is given as a row count, the byte width of a source row (which sets the inner dimension) and the byte width of a destination row (which sets the output column count). These shape values are captured on the start cycle. Result columns and rows that fall outside the shape are left at zero in the destination tile.

Top module: `tf32_tile_mma`

## Requirements
- R1: A source operand whose exponent field is 255, whose fraction is nonzero and whose fraction bit 22 is clear is made quiet before use. Every destination element fed by such an operand ends as the canonical quiet NaN 32'h7FC00000.
- R2: Bits [12:0] of every source operand (after NaN quieting) are cleared before the multiply. Bits [31:13] are kept. Example: 32'h3FC01FFF times 32'h40000FFF gives 32'h40400000.
- R3: With K = source bytes per row / 4 and N = destination bytes per row / 4, each active element becomes D[m][n] = D_old[m][n] + sum over k < K of A[m][k]*B[k][n]. Tile elements beyond K in A and B have no effect.
- R4: For each row, the products are summed in a temporary that starts at +0, walking k outer and n inner. The old destination value is added only after all K products. Example: three products of 1.0 added to 32'h4C000000 give 32'h4C000001.
- R5: When a row is written back, columns at index N and above are set to zero.
- R6: When the run ends, destination rows at index R and above are zero, where R is the configured row count.
- R7: Each multiply and each add rounds to nearest even. Denormal inputs and results become zero. An infinity propagates. Infinity times zero gives a NaN, and so does adding infinities of opposite sign. Any NaN result is 32'h7FC00000.
- R8: A start pulse while idle latches the shape and raises busy in the next cycle. Shape inputs changed afterwards have no effect on the run. A done pulse one cycle long marks the end of the run; busy is high during that cycle and low in the next, and done never repeats back to back.
- R9: Host writes made while busy is high change no tile element.
- R10: The host port encodes the tile select as 0 = A, 1 = B, 2 = destination; select 3 reads as zero and writes nowhere. Read data is registered: it shows the addressed element one clock after the address is presented, and it is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all tiles |
| start | input | 1 | Begins a run when idle |
| shape_rows | input | 5 | Active destination rows, 1..16 |
| shape_a_bytes | input | 7 | Bytes per source-A row, multiple of 4, 4..64 |
| shape_d_bytes | input | 7 | Bytes per destination row, multiple of 4, 4..64 |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse at the end of a run |
| tp_we | input | 1 | Host write enable (ignored while busy) |
| tp_sel | input | 2 | Tile select: 0 A, 1 B, 2 destination, 3 none |
| tp_row | input | 4 | Element row |
| tp_col | input | 4 | Element column |
| tp_wdata | input | 32 | Write data |
| tp_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default 16-row by 16-column geometry. This puts full-size runs in reach, where every loop counter wraps at its last index and no row or column is left to zero. The same geometry is also exercised with narrow shapes that leave most of the destination tile to be cleared. A behavioural model in real arithmetic, rounded to fp32 after each step, predicts every destination element. Directed runs cover the rounding tie that shows the order of accumulation, operand truncation, NaN and infinity cases, denormal flushing, and host writes that land during a run.

// File: rtl/tf32_mma_pkg.sv
package tf32_mma_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CANON_QNAN = 32'h7FC00000;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_D    = 2'd2,
        SEL_NONE = 2'd3
    } tile_sel_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MAC,
        PH_ADDD,
        PH_WB,
        PH_ZERO,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } fp32_t;

    // Quieten a signaling NaN, then keep only the TF32 part of the mantissa.
    function automatic fp32_t to_tf32(input fp32_t x);
        fp32_t y;
        y = x;
        if ((&x.exp) && (|x.frac) && !x.frac[22]) y.frac[22] = 1'b1;
        y.frac[12:0] = '0;
        return y;
    endfunction

    function automatic fp32_t fp_mul(input fp32_t a, input fp32_t b);
        logic        sg, a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, g, st, up;
        logic [47:0] prod;
        logic [24:0] mr;
        int          e;
        sg     = a.sign ^ b.sign;
        a_nan  = (&a.exp) && (|a.frac);
        b_nan  = (&b.exp) && (|b.frac);
        a_inf  = (&a.exp) && !(|a.frac);
        b_inf  = (&b.exp) && !(|b.frac);
        a_zero = (a.exp == 8'd0);
        b_zero = (b.exp == 8'd0);
        if (a_nan || b_nan) return fp32_t'(CANON_QNAN);
        if (a_inf || b_inf) begin
            if (a_zero || b_zero) return fp32_t'(CANON_QNAN);
            return '{sign: sg, exp: 8'hFF, frac: 23'd0};
        end
        if (a_zero || b_zero) return '{sign: sg, exp: 8'd0, frac: 23'd0};
        prod = 48'({1'b1, a.frac}) * 48'({1'b1, b.frac});
        e    = int'(a.exp) + int'(b.exp) - 127;
        if (prod[47]) e = e + 1;
        else          prod = prod << 1;
        g  = prod[23];
        st = |prod[22:0];
        up = g & (st | prod[24]);
        mr = {1'b0, prod[47:24]} + 25'(up);
        if (mr[24]) begin
            e  = e + 1;
            mr = mr >> 1;
        end
        if (e >= 255) return '{sign: sg, exp: 8'hFF, frac: 23'd0};
        if (e <= 0)   return '{sign: sg, exp: 8'd0, frac: 23'd0};
        return '{sign: sg, exp: 8'(e), frac: mr[22:0]};
    endfunction

    function automatic fp32_t fp_add(input fp32_t a, input fp32_t b);
        fp32_t       x, y;
        logic        a_inf, b_inf, lost, g, st, up;
        logic [26:0] mx, my, ysh;
        logic [27:0] s;
        logic [24:0] mr;
        int          d, e;
        a_inf = (&a.exp) && !(|a.frac);
        b_inf = (&b.exp) && !(|b.frac);
        if (((&a.exp) && (|a.frac)) || ((&b.exp) && (|b.frac))) return fp32_t'(CANON_QNAN);
        if (a_inf && b_inf) return (a.sign == b.sign) ? a : fp32_t'(CANON_QNAN);
        if (a_inf) return a;
        if (b_inf) return b;
        if (a.exp == 8'd0 && b.exp == 8'd0) return '{sign: a.sign & b.sign, exp: 8'd0, frac: 23'd0};
        if (a.exp == 8'd0) return b;
        if (b.exp == 8'd0) return a;
        if ({b.exp, b.frac} > {a.exp, a.frac}) begin
            x = b; y = a;
        end else begin
            x = a; y = b;
        end
        d  = int'(x.exp) - int'(y.exp);
        e  = int'(x.exp);
        mx = {1'b1, x.frac, 3'b000};
        my = {1'b1, y.frac, 3'b000};
        if (d >= 27) begin
            ysh  = '0;
            lost = 1'b1;
        end else begin
            ysh  = my >> d;
            lost = |(my & ((27'd1 << d) - 27'd1));
        end
        ysh[0] = ysh[0] | lost;
        if (x.sign == y.sign) begin
            s = {1'b0, mx} + {1'b0, ysh};
            if (s[27]) begin
                s = {1'b0, s[27:1]} | {27'd0, s[0]};
                e = e + 1;
            end
        end else begin
            s = {1'b0, mx} - {1'b0, ysh};
            if (s == 28'd0) return '0;
            for (int i = 0; i < 27; i++) begin
                if (!s[26]) begin
                    s = s << 1;
                    e = e - 1;
                end
            end
        end
        g  = s[2];
        st = |s[1:0];
        up = g & (st | s[3]);
        mr = {1'b0, s[26:3]} + 25'(up);
        if (mr[24]) begin
            e  = e + 1;
            mr = mr >> 1;
        end
        if (e >= 255) return '{sign: x.sign, exp: 8'hFF, frac: 23'd0};
        if (e <= 0)   return '{sign: x.sign, exp: 8'd0, frac: 23'd0};
        return '{sign: x.sign, exp: 8'(e), frac: mr[22:0]};
    endfunction

endpackage

// File: rtl/tf32_tile_bank.sv
module tf32_tile_bank
    import tf32_mma_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         hst_we,
    input  logic [RW-1:0]                hst_row,
    input  logic [CW-1:0]                hst_col,
    input  logic [WORD_W-1:0]            hst_wdata,
    output logic [WORD_W-1:0]            hst_rdata,
    input  logic [RW-1:0]                eng_row,
    input  logic [CW-1:0]                eng_col,
    output logic [WORD_W-1:0]            eng_rdata,
    input  logic                         row_we,
    input  logic [RW-1:0]                row_idx,
    input  logic [COLS-1:0][WORD_W-1:0]  row_wdata,
    input  logic                         clr_en,
    input  logic [RW:0]                  clr_from
);

    logic [COLS-1:0][WORD_W-1:0] mem [ROWS];

    assign hst_rdata = mem[hst_row][hst_col];
    assign eng_rdata = mem[eng_row][eng_col];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else begin
            if (hst_we) mem[hst_row][hst_col] <= hst_wdata;
            if (row_we) mem[row_idx] <= row_wdata;
            if (clr_en) begin
                for (int r = 0; r < ROWS; r++) begin
                    if ((RW+1)'(r) >= clr_from) mem[r] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tf32_mac_unit.sv
module tf32_mac_unit
    import tf32_mma_pkg::*;
(
    input  logic [WORD_W-1:0] a_raw,
    input  logic [WORD_W-1:0] b_raw,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] dsrc,
    input  logic              use_prod,
    output logic [WORD_W-1:0] sum
);

    fp32_t prod;

    always_comb begin
        prod = fp_mul(to_tf32(fp32_t'(a_raw)), to_tf32(fp32_t'(b_raw)));
        sum  = fp_add(fp32_t'(acc), use_prod ? prod : fp32_t'(dsrc));
    end

endmodule

// File: rtl/tf32_mma_seq.sv
module tf32_mma_seq
    import tf32_mma_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [RW:0]                  shape_rows,
    input  logic [CW+2:0]                shape_a_bytes,
    input  logic [CW+2:0]                shape_d_bytes,
    output logic                         busy,
    output logic                         done,
    output logic [RW-1:0]                m_idx,
    output logic [CW-1:0]                k_idx,
    output logic [CW-1:0]                n_idx,
    output logic                         use_prod,
    output logic [WORD_W-1:0]            acc,
    input  logic [WORD_W-1:0]            sum_in,
    output logic                         row_we,
    output logic [COLS-1:0][WORD_W-1:0]  row_wdata,
    output logic                         clr_en,
    output logic [RW:0]                  clr_from
);

    phase_e                      phase;
    logic [RW-1:0]               m_q;
    logic [CW-1:0]               k_q, n_q;
    logic [RW:0]                 rows_lim;
    logic [CW+2:0]               k_lim, n_lim;
    logic [COLS-1:0][WORD_W-1:0] tmp;
    logic                        n_last, k_last, m_last;

    assign n_last = ((CW+3)'(n_q) + (CW+3)'(1)) == n_lim;
    assign k_last = ((CW+3)'(k_q) + (CW+3)'(1)) == k_lim;
    assign m_last = ((RW+1)'(m_q) + (RW+1)'(1)) == rows_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            m_q      <= '0;
            k_q      <= '0;
            n_q      <= '0;
            rows_lim <= '0;
            k_lim    <= '0;
            n_lim    <= '0;
            tmp      <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    rows_lim <= shape_rows;
                    k_lim    <= shape_a_bytes >> 2;
                    n_lim    <= shape_d_bytes >> 2;
                    m_q      <= '0;
                    k_q      <= '0;
                    n_q      <= '0;
                    tmp      <= '0;
                    phase    <= PH_MAC;
                end
                PH_MAC: begin
                    tmp[n_q] <= sum_in;
                    if (n_last) begin
                        n_q <= '0;
                        if (k_last) begin
                            k_q   <= '0;
                            phase <= PH_ADDD;
                        end else begin
                            k_q <= k_q + 1'b1;
                        end
                    end else begin
                        n_q <= n_q + 1'b1;
                    end
                end
                PH_ADDD: begin
                    tmp[n_q] <= sum_in;
                    if (n_last) begin
                        n_q   <= '0;
                        phase <= PH_WB;
                    end else begin
                        n_q <= n_q + 1'b1;
                    end
                end
                PH_WB: begin
                    tmp <= '0;
                    if (m_last) begin
                        phase <= PH_ZERO;
                    end else begin
                        m_q   <= m_q + 1'b1;
                        phase <= PH_MAC;
                    end
                end
                PH_ZERO: phase <= PH_DONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            row_wdata[c] = ((CW+3)'(c) < n_lim) ? tmp[c] : '0;
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign done     = (phase == PH_DONE);
    assign m_idx    = m_q;
    assign k_idx    = k_q;
    assign n_idx    = n_q;
    assign use_prod = (phase == PH_MAC);
    assign acc      = tmp[n_q];
    assign row_we   = (phase == PH_WB);
    assign clr_en   = (phase == PH_ZERO);
    assign clr_from = rows_lim;

endmodule

// File: rtl/tf32_tile_mma.sv
module tf32_tile_mma
    import tf32_mma_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int NUM_TILES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RW:0]       shape_rows,
    input  logic [CW+2:0]     shape_a_bytes,
    input  logic [CW+2:0]     shape_d_bytes,
    output logic              busy,
    output logic              done,
    input  logic              tp_we,
    input  logic [1:0]        tp_sel,
    input  logic [RW-1:0]     tp_row,
    input  logic [CW-1:0]     tp_col,
    input  logic [WORD_W-1:0] tp_wdata,
    output logic [WORD_W-1:0] tp_rdata
);

    logic [RW-1:0]               m_idx;
    logic [CW-1:0]               k_idx, n_idx;
    logic                        use_prod, d_row_we, clr_en;
    logic [RW:0]                 clr_from;
    logic [WORD_W-1:0]           acc, sum;
    logic [COLS-1:0][WORD_W-1:0] d_row_wdata;

    logic [WORD_W-1:0] hst_rd  [NUM_TILES];
    logic [WORD_W-1:0] eng_rd  [NUM_TILES];
    logic [RW-1:0]     eng_row [NUM_TILES];
    logic [CW-1:0]     eng_col [NUM_TILES];

    // Engine addressing: A by (m,k), B by (k,n), destination by (m,n).
    assign eng_row[SEL_A] = m_idx;
    assign eng_col[SEL_A] = k_idx;
    assign eng_row[SEL_B] = RW'(k_idx);
    assign eng_col[SEL_B] = n_idx;
    assign eng_row[SEL_D] = m_idx;
    assign eng_col[SEL_D] = n_idx;

    generate
        for (genvar g = 0; g < NUM_TILES; g++) begin : g_tile
            localparam bit IS_DEST = (g == int'(SEL_D));
            tf32_tile_bank #(.ROWS(ROWS), .COLS(COLS)) i_bank (
                .clk       (clk),
                .rst       (rst),
                .hst_we    (tp_we && !busy && (tp_sel == 2'(g))),
                .hst_row   (tp_row),
                .hst_col   (tp_col),
                .hst_wdata (tp_wdata),
                .hst_rdata (hst_rd[g]),
                .eng_row   (eng_row[g]),
                .eng_col   (eng_col[g]),
                .eng_rdata (eng_rd[g]),
                .row_we    (IS_DEST ? d_row_we : 1'b0),
                .row_idx   (m_idx),
                .row_wdata (d_row_wdata),
                .clr_en    (IS_DEST ? clr_en : 1'b0),
                .clr_from  (clr_from)
            );
        end
    endgenerate

    tf32_mma_seq #(.ROWS(ROWS), .COLS(COLS)) i_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .shape_rows    (shape_rows),
        .shape_a_bytes (shape_a_bytes),
        .shape_d_bytes (shape_d_bytes),
        .busy          (busy),
        .done          (done),
        .m_idx         (m_idx),
        .k_idx         (k_idx),
        .n_idx         (n_idx),
        .use_prod      (use_prod),
        .acc           (acc),
        .sum_in        (sum),
        .row_we        (d_row_we),
        .row_wdata     (d_row_wdata),
        .clr_en        (clr_en),
        .clr_from      (clr_from)
    );

    tf32_mac_unit i_mac (
        .a_raw    (eng_rd[SEL_A]),
        .b_raw    (eng_rd[SEL_B]),
        .acc      (acc),
        .dsrc     (eng_rd[SEL_D]),
        .use_prod (use_prod),
        .sum      (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tp_rdata <= '0;
        end else begin
            case (tile_sel_e'(tp_sel))
                SEL_A:   tp_rdata <= hst_rd[SEL_A];
                SEL_B:   tp_rdata <= hst_rd[SEL_B];
                SEL_D:   tp_rdata <= hst_rd[SEL_D];
                default: tp_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/tf32_mma_checker.sv
module tf32_mma_checker
    import tf32_mma_pkg::*;
#(
    parameter int COLS = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         busy,
    input logic                         done,
    input logic                         d_row_we,
    input logic [COLS-1:0][WORD_W-1:0]  d_row_wdata
);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_done_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_start_raises_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            // R7: a NaN leaving the datapath is always the canonical one
            assert_canon_nan_R7: assert property (@(posedge clk) disable iff (rst)
                (d_row_we && (&d_row_wdata[c][30:23]) && (|d_row_wdata[c][22:0]))
                    |-> (d_row_wdata[c] == CANON_QNAN));
            // R7: no denormal is ever written back
            assert_no_denormal_R7: assert property (@(posedge clk) disable iff (rst)
                (d_row_we && (d_row_wdata[c][30:23] == 8'd0)) |-> (d_row_wdata[c][22:0] == 23'd0));
        end
    endgenerate

endmodule

bind tf32_tile_mma tf32_mma_checker #(.COLS(COLS)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .d_row_we    (d_row_we),
    .d_row_wdata (d_row_wdata)
);

// File: tb/test_tf32_tile_mma.sv
`timescale 1ns/1ps
module test_tf32_tile_mma;

    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam logic [31:0] QN = 32'h7FC00000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  shape_rows;
    logic [6:0]  shape_a_bytes, shape_d_bytes;
    logic        busy, done;
    logic        tp_we;
    logic [1:0]  tp_sel;
    logic [3:0]  tp_row, tp_col;
    logic [31:0] tp_wdata, tp_rdata;

    always #4 clk = ~clk;

    tf32_tile_mma i_tf32_tile_mma (.*);

    logic [31:0] ta [ROWS][COLS];
    logic [31:0] tb [ROWS][COLS];
    logic [31:0] td [ROWS][COLS];
    int n_chk = 0;
    int n_fail = 0;

    // ---------------- behavioural number model ----------------
    function automatic real f2r(logic [31:0] w);
        if (w[30:23] == 8'd0) return $bitstoreal({w[31], 63'd0});
        if (w[30:23] == 8'hFF) begin
            if (w[22:0] != 0) return $bitstoreal(64'h7FF8000000000000);
            return $bitstoreal({w[31], 11'h7FF, 52'd0});
        end
        return $bitstoreal({w[31], 11'(w[30:23]) + 11'd896, w[22:0], 29'd0});
    endfunction

    function automatic logic [31:0] r2f(real r);
        logic [63:0] d;
        logic [24:0] mr;
        int e;
        d = $realtobits(r);
        if (d[62:52] == 11'h7FF) return (d[51:0] != 0) ? QN : {d[63], 8'hFF, 23'd0};
        if (d[62:52] == 11'd0) return {d[63], 31'd0};
        e  = int'(d[62:52]) - 896;
        mr = {2'b01, d[51:29]};
        if (d[28] && ((|d[27:0]) || mr[0])) mr = mr + 25'd1;
        if (mr[24]) e = e + 1;
        if (e >= 255) return {d[63], 8'hFF, 23'd0};
        if (e <= 0) return {d[63], 31'd0};
        return {d[63], 8'(e), mr[24] ? 23'd0 : mr[22:0]};
    endfunction

    function automatic logic [31:0] trim(logic [31:0] w);
        logic [31:0] q;
        q = w;
        if (w[30:23] == 8'hFF && w[22:0] != 0) q = q | 32'h0040_0000;
        return q & 32'hFFFF_E000;
    endfunction

    // ---------------- bench helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int sel, input int r, input int c, input logic [31:0] w);
        @(negedge clk);
        tp_we = 1'b1; tp_sel = 2'(sel); tp_row = 4'(r); tp_col = 4'(c); tp_wdata = w;
        @(negedge clk);
        tp_we = 1'b0;
        if (sel == 0) ta[r][c] = w;
        if (sel == 1) tb[r][c] = w;
        if (sel == 2) td[r][c] = w;
    endtask

    task automatic get(input int sel, input int r, input int c, output logic [31:0] w);
        @(negedge clk);
        tp_we = 1'b0; tp_sel = 2'(sel); tp_row = 4'(r); tp_col = 4'(c);
        @(negedge clk);
        w = tp_rdata;
    endtask

    task automatic run(input int rows, input int ab, input int db, input bit poke);
        int cyc;
        @(negedge clk);
        shape_rows = 5'(rows); shape_a_bytes = 7'(ab); shape_d_bytes = 7'(db); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        shape_rows = 5'd16; shape_a_bytes = 7'd64; shape_d_bytes = 7'd64;
        check(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (poke && cyc < 3) begin
                tp_we = 1'b1; tp_sel = 2'(cyc); tp_row = 4'd0; tp_col = 4'd0; tp_wdata = 32'h4120_0000;
            end else begin
                tp_we = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        tp_we = 1'b0;
        check(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 idle after done", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic verify(input int rows, input int kk, input int nn);
        logic [31:0] expv [ROWS][COLS];
        logic [31:0] got;
        real acc;
        for (int m = 0; m < ROWS; m++) begin
            for (int n = 0; n < COLS; n++) begin
                if (m >= rows || n >= nn) begin
                    expv[m][n] = 32'd0;
                end else begin
                    acc = 0.0;
                    for (int k = 0; k < kk; k++) begin
                        acc = f2r(r2f(acc + f2r(r2f(f2r(trim(ta[m][k])) * f2r(trim(tb[k][n]))))));
                    end
                    expv[m][n] = r2f(acc + f2r(td[m][n]));
                end
            end
        end
        for (int m = 0; m < ROWS; m++) begin
            for (int n = 0; n < COLS; n++) begin
                get(2, m, n, got);
                if (m >= rows)    check(got == expv[m][n], "R6 row beyond shape", got, expv[m][n]);
                else if (n >= nn) check(got == expv[m][n], "R5 column beyond shape", got, expv[m][n]);
                else              check(got == expv[m][n], "R3 result element", got, expv[m][n]);
                td[m][n] = expv[m][n];
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] w;
        rst = 1'b1; start = 1'b0; tp_we = 1'b0; tp_sel = 2'd0; tp_row = 4'd0; tp_col = 4'd0;
        tp_wdata = 32'd0; shape_rows = 5'd1; shape_a_bytes = 7'd4; shape_d_bytes = 7'd4;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                ta[r][c] = 0; tb[r][c] = 0; td[r][c] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R8 reset idle", {30'd0, busy, done}, 32'd0);
        check(tp_rdata == 32'd0, "R10 reset read data", tp_rdata, 32'd0);

        // R10: one-cycle read latency and tile select encoding
        put(0, 2, 3, 32'h1234_5678);
        get(0, 2, 3, w);
        check(w == 32'h1234_5678, "R10 read after write", w, 32'h1234_5678);
        get(3, 2, 3, w);
        check(w == 32'd0, "R10 select 3 reads zero", w, 32'd0);
        get(2, 2, 3, w);
        check(w == 32'd0, "R10 select 2 distinct tile", w, 32'd0);

        // R3: full 16x16x16 run with small integers
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                put(0, r, c, r2f(real'(((r + 2*c) % 7) - 3)));
                put(1, r, c, r2f(real'(((3*r + c) % 5) - 2)));
                put(2, r, c, r2f(real'(r - c)));
            end
        run(16, 64, 64, 1'b0);
        verify(16, 16, 16);

        // R3 R5 R6: partial shape, garbage beyond it
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) put(2, r, c, r2f(real'(100 + r + c)));
        run(3, 20, 28, 1'b0);
        verify(3, 5, 7);

        // R2: truncation of both operands
        put(0, 0, 0, 32'h3FC0_1FFF);
        put(1, 0, 0, 32'h4000_0FFF);
        put(2, 0, 0, 32'd0);
        run(1, 4, 4, 1'b0);
        verify(1, 1, 1);
        get(2, 0, 0, w);
        check(w == 32'h4040_0000, "R2 truncated product", w, 32'h4040_0000);

        // R4: destination added after the products (rounding tie shows order)
        for (int k = 0; k < 3; k++) begin
            put(0, 0, k, 32'h3F80_0000);
            put(1, k, 0, 32'h3F80_0000);
        end
        put(2, 0, 0, 32'h4C00_0000);
        run(1, 12, 4, 1'b0);
        verify(1, 3, 1);
        get(2, 0, 0, w);
        check(w == 32'h4C00_0001, "R4 accumulate then add destination", w, 32'h4C00_0001);

        // R1 R7: NaN and infinity handling
        put(0, 0, 0, 32'h7F80_0001); put(0, 0, 1, 32'h3F80_0000);
        put(0, 1, 0, 32'h7F80_0000); put(0, 1, 1, 32'h3F80_0000);
        put(1, 0, 0, 32'h4000_0000); put(1, 0, 1, 32'h0000_0000); put(1, 0, 2, 32'hBF80_0000);
        for (int c = 0; c < 3; c++) put(1, 1, c, 32'h3F80_0000);
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++) put(2, r, c, 32'd0);
        run(2, 8, 12, 1'b0);
        verify(2, 2, 3);
        get(2, 0, 0, w); check(w == QN, "R1 signaling NaN operand", w, QN);
        get(2, 0, 2, w); check(w == QN, "R1 signaling NaN operand", w, QN);
        get(2, 1, 0, w); check(w == 32'h7F80_0000, "R7 infinity propagates", w, 32'h7F80_0000);
        get(2, 1, 1, w); check(w == QN, "R7 infinity times zero", w, QN);
        get(2, 1, 2, w); check(w == 32'hFF80_0000, "R7 negative infinity", w, 32'hFF80_0000);

        // R7: denormal operand and destination flushed
        put(0, 0, 0, 32'h0040_0000);
        put(1, 0, 0, 32'h7F00_0000);
        put(2, 0, 0, 32'h0000_0001);
        run(1, 4, 4, 1'b0);
        verify(1, 1, 1);
        get(2, 0, 0, w);
        check(w == 32'd0, "R7 denormal flushed", w, 32'd0);

        // R9: host writes while busy are ignored
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                put(0, r, c, r2f(real'(r + c + 1)));
                put(1, r, c, r2f(real'(r - c)));
                put(2, r, c, r2f(real'(2 * r)));
            end
        run(4, 16, 16, 1'b1);
        verify(4, 4, 4);
        get(0, 0, 0, w);
        check(w == ta[0][0], "R9 A unchanged by busy write", w, ta[0][0]);
        get(1, 0, 0, w);
        check(w == tb[0][0], "R9 B unchanged by busy write", w, tb[0][0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule